// File: doc/BRIEF.md
# Alternating Energy Pulse Generator

This block turns a stream of signed active-power words into energy pulses for an electromechanical register. It accepts one power word per averaging period and adds the word's magnitude to an energy accumulator. The sign is dropped, so power flowing in either direction counts as energy. Each time the accumulated energy reaches a full-scale quantum, the block owes one pulse. It issues these pulses as long active-low strokes. The strokes go to two outputs in turn, so the pair can drive a two-coil stepper motor or a counter directly.

A 3-bit rate select scales power to pulse rate. Only its two low bits matter. Every step up in those bits halves the energy quantum, which doubles the pulse rate. Pulse timing comes from a clocks-per-millisecond parameter, so all durations scale with the clock frequency. The block keeps energy that arrives while a stroke is still being driven in a small pending counter. Those pulses are issued later, back to back, and are not dropped.

Top module: `alt_energy_pulser`

## Requirements
- R1: While `rst` is high on a clock edge, the accumulator, the pending count and the output turn are all cleared. Both `pulse1_n` and `pulse2_n` read 1 after that edge. No pulse appears after reset until a quantum has been accumulated.
- R2: Every pulse drives one output to 0 for exactly 250*CLK_PER_MS clock cycles, then returns it to 1.
- R3: Pulses alternate between the two outputs. The first pulse after reset goes on `pulse1_n`.
- R4: The energy quantum is WORDS_PER_SEC * 2^(PWR_W - s) in magnitude units, where s = `freq_sel[1:0]` read as an unsigned value. The block emits exactly one pulse for each whole quantum accumulated. A constant full-scale magnitude of 2^(PWR_W-1) per word, at WORDS_PER_SEC words per second, therefore gives 0.25, 0.5, 1 or 2 pulses per second on each output for s = 0, 1, 2, 3.
- R5: The magnitude of a word is its absolute value in two's complement. The most negative word counts as 2^(PWR_W-1). Negative and positive words of equal magnitude add the same energy.
- R6: `freq_sel[2]` has no effect on the outputs.
- R7: A quantum completed while a pulse is in progress is queued. The queued pulse starts on the clock edge after the running one ends, so the outputs show one all-high cycle between pulses and consecutive falling edges are 250*CLK_PER_MS+1 cycles apart.
- R8: `pulse1_n` and `pulse2_n` are never 0 at the same time.
- R9: Reaching a quantum subtracts it from the accumulator. The remainder carries into the next quantum.
- R10: With the block idle and nothing queued, suppose a word is taken on clock edge e and completes a quantum. The pulse output then falls on edge e+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_word | input | PWR_W | Signed active-power word, two's complement |
| pwr_valid | input | 1 | High for one cycle per power word taken |
| freq_sel | input | 3 | Rate select; bits [1:0] scale the quantum, bit 2 unused |
| pulse1_n | output | 1 | First energy pulse line, active low |
| pulse2_n | output | 1 | Second energy pulse line, active low |

## Verification
The bench builds the block with PWR_W=8, WORDS_PER_SEC=4, CLK_PER_MS=4 and PEND_W=3. With these values a stroke is 1000 cycles long and the four quanta are 128, 256, 512 and 1024. This lets the bench reach every rate setting, exact threshold crossings and carried remainders within a short run. Random bursts of words arriving faster than strokes can drain fill the three-bit pending counter to saturation. The bench then checks that the energy held back in the accumulator still yields the exact pulse total.

// File: rtl/pg_pkg.sv
package pg_pkg;
    // Stroke length in milliseconds; multiplied by the clocks-per-ms parameter.
    localparam int unsigned STROKE_MS = 250;

    // Which output line carries the next stroke.
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/pg_magnitude.sv
module pg_magnitude #(
    parameter int unsigned PWR_W = 16
) (
    input  logic [PWR_W-1:0] word_i,
    output logic [PWR_W-1:0] mag_o
);
    // Two's complement absolute value; the most negative code maps to 2^(PWR_W-1),
    // which is representable because the result is unsigned.
    always_comb begin
        if (word_i[PWR_W-1]) begin
            mag_o = ~word_i + PWR_W'(1);
        end else begin
            mag_o = word_i;
        end
    end
endmodule

// File: rtl/pg_energy_acc.sv
module pg_energy_acc #(
    parameter int unsigned PWR_W         = 16,
    parameter int unsigned WORDS_PER_SEC = 10,
    parameter int unsigned PEND_W        = 4,
    parameter int unsigned ACC_W         = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_en,
    input  logic [PWR_W-1:0]  mag_i,
    input  logic [1:0]        rate_sel,
    input  logic              take_i,
    output logic [PEND_W-1:0] pend_o
);
    localparam logic [ACC_W-1:0]  THR_BASE = ACC_W'(WORDS_PER_SEC) << PWR_W;
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [PEND_W-1:0] pend;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] thr;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_in;
    logic             room;
    logic             inc;

    always_comb begin
        thr    = THR_BASE >> rate_sel;
        sum    = {1'b0, st_q.acc} + (add_en ? (ACC_W+1)'(mag_i) : '0);
        acc_in = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
        // A crossing is booked only when the pending counter can take it;
        // otherwise the energy stays in the accumulator for a later cycle.
        room   = (st_q.pend != PEND_MAX) || take_i;
        inc    = (st_q.acc >= thr) && room;
        st_d.acc  = inc ? (acc_in - thr) : acc_in;
        st_d.pend = st_q.pend + PEND_W'(inc) - PEND_W'(take_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/pg_pulse_seq.sv
module pg_pulse_seq
    import pg_pkg::*;
#(
    parameter int unsigned PW_CYC = 1024000,
    parameter int unsigned CNT_W  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pend_nz,
    output logic take_o,
    output logic out1_n,
    output logic out2_n
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        side_e            side;
        logic             o1_n;
        logic             o2_n;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    take_c;

    always_comb begin
        st_d   = st_q;
        take_c = !st_q.busy && pend_nz;
        if (take_c) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PW_CYC - 1);
            if (st_q.side == SIDE_A) begin
                st_d.o1_n = 1'b0;
                st_d.side = SIDE_B;
            end else begin
                st_d.o2_n = 1'b0;
                st_d.side = SIDE_A;
            end
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.o1_n = 1'b1;
                st_d.o2_n = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
            st_q.side <= SIDE_A;
            st_q.o1_n <= 1'b1;
            st_q.o2_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = take_c;
    assign out1_n = st_q.o1_n;
    assign out2_n = st_q.o2_n;
endmodule

// File: rtl/alt_energy_pulser.sv
module alt_energy_pulser
    import pg_pkg::*;
#(
    parameter int unsigned PWR_W         = 16,
    parameter int unsigned WORDS_PER_SEC = 10,
    parameter int unsigned CLK_PER_MS    = 4096,
    parameter int unsigned PEND_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWR_W-1:0] pwr_word,
    input  logic             pwr_valid,
    input  logic [2:0]       freq_sel,
    output logic             pulse1_n,
    output logic             pulse2_n
);
    localparam int unsigned PW_CYC = STROKE_MS * CLK_PER_MS;
    localparam int unsigned CNT_W  = $clog2(PW_CYC + 1);
    localparam int unsigned ACC_W  = $clog2(WORDS_PER_SEC + 1) + PWR_W + 2;

    logic [PWR_W-1:0]  mag;
    logic [PEND_W-1:0] pend_cnt;
    logic              take;
    logic              sel_hi_unused;

    assign sel_hi_unused = freq_sel[2];

    pg_magnitude #(.PWR_W(PWR_W)) u_mag (
        .word_i (pwr_word),
        .mag_o  (mag)
    );

    pg_energy_acc #(
        .PWR_W        (PWR_W),
        .WORDS_PER_SEC(WORDS_PER_SEC),
        .PEND_W       (PEND_W),
        .ACC_W        (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .add_en   (pwr_valid),
        .mag_i    (mag),
        .rate_sel (freq_sel[1:0]),
        .take_i   (take),
        .pend_o   (pend_cnt)
    );

    pg_pulse_seq #(
        .PW_CYC(PW_CYC),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pend_nz (pend_cnt != '0),
        .take_o  (take),
        .out1_n  (pulse1_n),
        .out2_n  (pulse2_n)
    );
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
    parameter int unsigned CLK_PER_MS = 4096,
    parameter int unsigned PEND_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pulse1_n,
    input logic              pulse2_n,
    input logic [PEND_W-1:0] pend_cnt
);
    localparam int unsigned PW_CYC = pg_pkg::STROKE_MS * CLK_PER_MS;

    logic [31:0] low_cnt;
    logic [1:0]  last_q;
    logic        p1_q, p2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            last_q  <= 2'd0;
            p1_q    <= 1'b1;
            p2_q    <= 1'b1;
        end else begin
            low_cnt <= (!pulse1_n || !pulse2_n) ? low_cnt + 32'd1 : 32'd0;
            p1_q    <= pulse1_n;
            p2_q    <= pulse2_n;
            if (p1_q && !pulse1_n) last_q <= 2'd1;
            else if (p2_q && !pulse2_n) last_q <= 2'd2;
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pulse1_n && pulse2_n));

    assert_stroke_width_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pulse1_n) || $rose(pulse2_n)) |-> (low_cnt == PW_CYC));

    assert_first_line_turn_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse1_n) |-> (last_q != 2'd1));

    assert_second_line_turn_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse2_n) |-> (last_q == 2'd1));

    assert_queue_served_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt != '0 && pulse1_n && pulse2_n) |=> (!pulse1_n || !pulse2_n));

    assert_never_both_low_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse1_n || pulse2_n));
endmodule

bind alt_energy_pulser pg_checker #(
    .CLK_PER_MS(CLK_PER_MS),
    .PEND_W    (PEND_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pulse1_n (pulse1_n),
    .pulse2_n (pulse2_n),
    .pend_cnt (pend_cnt)
);

// File: tb/sim_alt_energy_pulser.sv
`timescale 1ns/1ps
module sim_alt_energy_pulser;
    localparam int PWR_W = 8;
    localparam int WPS   = 4;
    localparam int CPMS  = 4;
    localparam int PEND_W = 3;
    localparam int PW    = 250 * CPMS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PWR_W-1:0] pwr_word = '0;
    logic             pwr_valid = 1'b0;
    logic [2:0]       freq_sel = 3'd3;
    logic             pulse1_n, pulse2_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int pulses = 0;
    int last_side = 0;
    int fall_cyc = 0;
    int last_fall = -1;
    int last_gap = 0;
    bit prev1 = 1'b1, prev2 = 1'b1;
    bit done = 1'b0;

    alt_energy_pulser #(
        .PWR_W(PWR_W), .WORDS_PER_SEC(WPS), .CLK_PER_MS(CPMS), .PEND_W(PEND_W)
    ) u0 (
        .clk(clk), .rst(rst), .pwr_word(pwr_word), .pwr_valid(pwr_valid),
        .freq_sel(freq_sel), .pulse1_n(pulse1_n), .pulse2_n(pulse2_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int quantum(input int sel);
        return WPS * (1 << (PWR_W - (sel % 4)));
    endfunction

    function automatic int magn(input logic [PWR_W-1:0] w);
        int v;
        v = int'($signed(w));
        return (v < 0) ? -v : v;
    endfunction

    // Output monitor: widths, turn order, spacing, overlap.
    always @(negedge clk) begin
        if (rst) begin
            last_side = 0;
            last_fall = -1;
        end else begin
            if (!pulse1_n && !pulse2_n) check(1'b0, "R8 both low", 0, 1);
            if (prev1 && !pulse1_n) begin
                check(last_side != 1, "R3 turn on line1", last_side, 2);
                last_side = 1;
                fall_cyc = cyc;
                pulses++;
                if (last_fall >= 0) begin
                    last_gap = cyc - last_fall;
                    check(last_gap >= PW + 1, "R7 fall spacing", last_gap, PW + 1);
                end
                last_fall = cyc;
            end
            if (prev2 && !pulse2_n) begin
                check(last_side == 1, "R3 turn on line2", last_side, 1);
                last_side = 2;
                fall_cyc = cyc;
                pulses++;
                if (last_fall >= 0) begin
                    last_gap = cyc - last_fall;
                    check(last_gap >= PW + 1, "R7 fall spacing", last_gap, PW + 1);
                end
                last_fall = cyc;
            end
            if ((!prev1 && pulse1_n) || (!prev2 && pulse2_n))
                check(cyc - fall_cyc == PW, "R2 stroke width", cyc - fall_cyc, PW);
        end
        prev1 = pulse1_n;
        prev2 = pulse2_n;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pwr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pulses = 0;
        check(pulse1_n && pulse2_n, "R1 outputs high after reset", {pulse1_n, pulse2_n}, 3);
    endtask

    task automatic send(input logic [PWR_W-1:0] w);
        @(negedge clk);
        pwr_word = w;
        pwr_valid = 1'b1;
        @(negedge clk);
        pwr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 5) begin
            @(negedge clk);
            quiet = (pulse1_n && pulse2_n) ? quiet + 1 : 0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        // R1: reset state, and nothing appears without energy
        freq_sel = 3'd3;
        do_reset();
        repeat (20) @(negedge clk);
        check(pulses == 0, "R1 no pulse without energy", pulses, 0);

        // R9/R10: just below quantum, then exact crossing with latency
        send(8'sd127);
        repeat (20) @(negedge clk);
        check(pulses == 0, "R9 below quantum no pulse", pulses, 0);
        send(8'sd1);
        check(pulse1_n == 1'b1, "R10 high at e", pulse1_n, 1);
        @(negedge clk);
        check(pulse1_n == 1'b1, "R10 high at e+1", pulse1_n, 1);
        @(negedge clk);
        check(pulse1_n == 1'b0, "R10 low at e+2 on line1", pulse1_n, 0);
        wait_idle();
        check(pulses == 1, "R4 one quantum one pulse", pulses, 1);

        // R9: remainder carry, R3 second pulse on line2
        do_reset();
        send(8'sd100);
        send(8'sd100);
        wait_idle();
        check(pulses == 1, "R9 first of carried pair", pulses, 1);
        send(8'sd56);
        wait_idle();
        check(pulses == 2, "R9 remainder completes quantum", pulses, 2);
        check(last_side == 2, "R3 second pulse on line2", last_side, 2);

        // R5: most negative word is a full quantum at sel 3
        do_reset();
        send(8'h80);
        wait_idle();
        check(pulses == 1, "R5 negative magnitude", pulses, 1);

        // R7: three back-to-back quanta queue and drain
        do_reset();
        @(negedge clk);
        pwr_word = 8'h80;
        pwr_valid = 1'b1;
        repeat (3) @(negedge clk);
        pwr_valid = 1'b0;
        wait_idle();
        check(pulses == 3, "R7 queued pulses all issued", pulses, 3);
        check(last_gap == PW + 1, "R7 back-to-back spacing", last_gap, PW + 1);
        check(last_side == 1, "R3 third pulse on line1", last_side, 1);

        // R4/R6: every select code, exact quantum boundaries
        for (int s = 0; s < 8; s++) begin
            int nw;
            freq_sel = 3'(s);
            do_reset();
            nw = 2 * quantum(s) / 128 - 1;
            for (int k = 0; k < nw; k++) send(8'h80);
            wait_idle();
            check(pulses == 1, (s >= 4) ? "R6 sel bit2 ignored, count below boundary" : "R4 count below boundary", pulses, 1);
            send(8'sd127);
            send(8'sd1);
            wait_idle();
            check(pulses == 2, (s >= 4) ? "R6 sel bit2 ignored, count at boundary" : "R4 count at boundary", pulses, 2);
        end

        // Random rounds: total pulses = floor(sum |word| / quantum)
        for (int r = 0; r < 4; r++) begin
            int s, total;
            s = int'($urandom % 8);
            freq_sel = 3'(s);
            do_reset();
            total = 0;
            for (int k = 0; k < 24; k++) begin
                logic [PWR_W-1:0] w;
                w = PWR_W'($urandom);
                total += magn(w);
                send(w);
                repeat (50 + int'($urandom % 350)) @(negedge clk);
            end
            wait_idle();
            check(pulses == total / quantum(s), "R4 R5 random energy total", pulses, total / quantum(s));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule